// File: doc/BRIEF.md
# In-Place Interleaved Extrinsic Memory Controller

This block owns the single storage array of an iterative two-code soft decoder. The array holds the a priori value for every bit position of the frame. It also takes the extrinsic value that the external datapath computes from that a priori value. Every result goes back to the location its input came from, so no separate interleave or deinterleave buffer is needed. In the first half of each iteration the array is read in natural order. In the second half the read order comes from a fixed interleaver permutation, and the write-back to the same address undoes that permutation.

After a start pulse the controller runs a programmed number of iterations, each made of two half-iterations. For every index it issues one read and presents the a priori value to the datapath. It keeps the read address in a delay line whose length matches the datapath latency, and the delayed address becomes the write address. Between half-iterations it waits until the last write has landed. After the final half, or after any half at whose end the stop input is high, it gives a one-cycle done pulse. The first half of a run presents zero as a priori information, so the array never has to be cleared.

The permutation is `perm(k) = (k*STRIDE + OFFSET) mod N`. STRIDE must be coprime with N.

Top module: `ext_inplace_ctrl`

## Requirements
- R1: After reset, `apri_valid` and `done` are 0 until a start pulse is accepted.
- R2: In the first half-iteration of a run, N values are presented on consecutive cycles, all equal to 0, with `ilv_phase` = 0.
- R3: In every second half of an iteration (half number odd, counting from 0), the k-th value presented is the array content at address `perm(k)`, and `ilv_phase` = 1.
- R4: `ext_data` is written to the address of the read it belongs to, in the cycle DP_LAT cycles after that read's `apri_valid` cycle. No other value changes that entry.
- R5: In the first half of every iteration after the first, the k-th value presented is the array content at address k, and `ilv_phase` = 0.
- R6: A run has 2*`iter_cnt` half-iterations. An `iter_cnt` of 0 counts as 1, and a value above MAX_ITER counts as MAX_ITER.
- R7: `done` is high for exactly one cycle, DP_LAT+1 cycles after the last `apri_valid` of the run. `apri_valid` is low in that cycle.
- R8: `stop` is sampled in the last drain cycle of each half. If it is high, the run ends after that half with the `done` pulse of R7.
- R9: A start pulse that arrives while a run is in progress is ignored. The run keeps its half count and gives a single `done`.
- R10: Within a run, the first value of a half comes DP_LAT+2 cycles after the last value of the previous half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the controller is idle |
| iter_cnt | input | CNT_W | Number of iterations, sampled at start |
| stop | input | 1 | Early-stop request, sampled at the end of each half |
| ext_data | input | DATA_W | Extrinsic result from the datapath, DP_LAT cycles after its a priori value |
| apri_valid | output | 1 | A priori value present on `apri_data` |
| apri_data | output | DATA_W | A priori value for the current index |
| ilv_phase | output | 1 | 1 when the presented value belongs to an interleaved half |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The read of one index and the write-back of an index read DP_LAT+1 cycles earlier share every cycle of a half. The bench drives a fresh random extrinsic value for each read at exactly the latency. It then judges, in the next half, that each address returns the value last written to it, in linear or permuted order. Because every half is checked against a bench model of the whole array, a write sent to a wrong or late address shows up as a data mismatch. The cycle gaps across half boundaries and up to `done` are measured, which shows that no read of a new half overlaps a pending write.

// File: rtl/ext_mem_pkg.sv
package ext_mem_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_t;

   function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
   parameter int unsigned N      = 448,
   parameter int unsigned STRIDE = 139,
   parameter int unsigned OFFSET = 17,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] addr
);

   localparam bit POW2 = ((N & (N - 1)) == 0);

   if (POW2) begin : g_mask
      always_comb begin
         longint unsigned raw;
         raw  = longint'(idx) * longint'(STRIDE) + longint'(OFFSET);
         addr = IDX_W'(raw);
      end
   end else begin : g_mod
      always_comb begin
         longint unsigned raw;
         raw  = longint'(idx) * longint'(STRIDE) + longint'(OFFSET);
         addr = IDX_W'(raw % longint'(N));
      end
   end

endmodule

// File: rtl/addr_delay_line.sv
module addr_delay_line #(
   parameter int unsigned AW     = 9,
   parameter int unsigned STAGES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [AW-1:0] in_a,
   output logic          head_v,
   output logic          tail_v,
   output logic [AW-1:0] tail_a
);

   logic [STAGES-1:0] v_q;
   logic [AW-1:0]     a_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q[0] <= 1'b0;
            else        v_q[0] <= in_v;
         end
         always_ff @(posedge clk) a_q[0] <= in_a;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q[s] <= 1'b0;
            else        v_q[s] <= v_q[s-1];
         end
         always_ff @(posedge clk) a_q[s] <= a_q[s-1];
      end
   end

   assign head_v = v_q[0];
   assign tail_v = v_q[STAGES-1];
   assign tail_a = a_q[STAGES-1];

endmodule

// File: rtl/apri_ram.sv
module apri_ram #(
   parameter int unsigned DEPTH = 448,
   parameter int unsigned WIDTH = 6,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data
);

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
      if (rd_en) rd_data <= cells[rd_addr];
   end

endmodule

// File: rtl/ext_inplace_ctrl.sv
module ext_inplace_ctrl
   import ext_mem_pkg::*;
#(
   parameter int unsigned N        = 448,
   parameter int unsigned DATA_W   = 6,
   parameter int unsigned MAX_ITER = 6,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned DP_LAT   = 3,
   parameter int unsigned STRIDE   = 139,
   parameter int unsigned OFFSET   = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  iter_cnt,
   input  logic              stop,
   input  logic [DATA_W-1:0] ext_data,
   output logic              apri_valid,
   output logic [DATA_W-1:0] apri_data,
   output logic              ilv_phase,
   output logic              done
);

   localparam int unsigned IDX_W  = $clog2(N);
   localparam int unsigned HALF_W = $clog2(2 * MAX_ITER);
   localparam int unsigned LAT_W  = $clog2(DP_LAT + 1);

   if (N < 2) begin : g_bad_n
      $error("frame length must be at least 2");
   end
   if (DP_LAT < 1) begin : g_bad_lat
      $error("datapath latency must be at least 1");
   end
   if (MAX_ITER < 1 || MAX_ITER >= (1 << CNT_W)) begin : g_bad_iter
      $error("iteration limit must fit the count field");
   end
   if (OFFSET >= N) begin : g_bad_off
      $error("permutation offset must be below the frame length");
   end
   if (gcd_u(STRIDE, N) != 1) begin : g_bad_stride
      $error("stride must be coprime with the frame length");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("data width must be positive");
   end

   seq_state_t         state;
   logic [IDX_W-1:0]   idx;
   logic [HALF_W-1:0]  hcnt;
   logic [HALF_W-1:0]  hlast;
   logic [LAT_W-1:0]   dcnt;
   logic [CNT_W-1:0]   lim;

   logic               rd_en;
   logic [IDX_W-1:0]   rd_addr;
   logic [IDX_W-1:0]   perm_addr;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_addr;
   logic [DATA_W-1:0]  ram_q;
   logic               zero_q;
   logic               phase_q;

   always_comb begin
      if (iter_cnt == '0)                       lim = CNT_W'(1);
      else if (int'(iter_cnt) > int'(MAX_ITER)) lim = CNT_W'(MAX_ITER);
      else                                      lim = iter_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         idx   <= '0;
         hcnt  <= '0;
         hlast <= '0;
         dcnt  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  hlast <= HALF_W'(2 * int'(lim) - 1);
                  hcnt  <= '0;
                  idx   <= '0;
                  state <= SEQ_READ;
               end
            end
            SEQ_READ: begin
               if (idx == IDX_W'(N - 1)) begin
                  idx   <= '0;
                  dcnt  <= '0;
                  state <= SEQ_DRAIN;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            SEQ_DRAIN: begin
               if (dcnt == LAT_W'(DP_LAT)) begin
                  if (hcnt == hlast || stop) begin
                     done  <= 1'b1;
                     state <= SEQ_IDLE;
                  end else begin
                     hcnt  <= hcnt + HALF_W'(1);
                     state <= SEQ_READ;
                  end
               end else begin
                  dcnt <= dcnt + LAT_W'(1);
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   ilv_addr_gen #(
      .N      (N),
      .STRIDE (STRIDE),
      .OFFSET (OFFSET)
   ) u_perm (
      .idx  (idx),
      .addr (perm_addr)
   );

   assign rd_en   = (state == SEQ_READ);
   assign rd_addr = hcnt[0] ? perm_addr : idx;

   addr_delay_line #(
      .AW     (IDX_W),
      .STAGES (DP_LAT + 1)
   ) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (rd_en),
      .in_a   (rd_addr),
      .head_v (apri_valid),
      .tail_v (wr_en),
      .tail_a (wr_addr)
   );

   apri_ram #(
      .DEPTH (N),
      .WIDTH (DATA_W)
   ) u_ram (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (ram_q),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (ext_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_q  <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         zero_q  <= (hcnt == '0);
         phase_q <= hcnt[0];
      end
   end

   assign apri_data = zero_q ? '0 : ram_q;
   assign ilv_phase = phase_q;

endmodule

// File: rtl/ext_inplace_ctrl_chk.sv
module ext_inplace_ctrl_chk #(
   parameter int unsigned N     = 448,
   parameter int unsigned IDX_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             apri_valid,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_addr,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_addr
);

   // R7: end-of-run pulse lasts one cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: no value is presented with the end-of-run pulse
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !apri_valid);

   // R3: read addresses stay inside the frame
   p_rd_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (int'(rd_addr) < int'(N)));

   // R4: write-back addresses stay inside the frame
   p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < int'(N)));

   // R4: a write-back never targets the entry being read in the same cycle
   p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |-> (rd_addr != wr_addr));

   // R2: every presented value follows an issued read
   p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      apri_valid |-> $past(rd_en));

endmodule

bind ext_inplace_ctrl ext_inplace_ctrl_chk #(
   .N     (N),
   .IDX_W (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done       (done),
   .apri_valid (apri_valid),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr)
);

// File: tb/ext_inplace_ctrl_tb.sv
`timescale 1ns/1ps
module ext_inplace_ctrl_tb;

   localparam int N      = 448;
   localparam int DW     = 6;
   localparam int MAXIT  = 6;
   localparam int CW     = 3;
   localparam int LAT    = 3;
   localparam int STRIDE = 139;
   localparam int OFFSET = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] iter_cnt = '0;
   logic          stop = 1'b0;
   logic [DW-1:0] ext_data = '0;
   logic          apri_valid;
   logic [DW-1:0] apri_data;
   logic          ilv_phase;
   logic          done;

   always #10 clk = ~clk;

   ext_inplace_ctrl #(
      .N(N), .DATA_W(DW), .MAX_ITER(MAXIT), .CNT_W(CW),
      .DP_LAT(LAT), .STRIDE(STRIDE), .OFFSET(OFFSET)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .iter_cnt(iter_cnt),
      .stop(stop), .ext_data(ext_data), .apri_valid(apri_valid),
      .apri_data(apri_data), .ilv_phase(ilv_phase), .done(done)
   );

   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int perm(input int k);
      return (k * STRIDE + OFFSET) % N;
   endfunction

   // bench model and monitor state
   logic [DW-1:0] model [N];
   logic [DW-1:0] hist [16];
   int  cyc = 0;
   int  run_half = 0;
   int  run_k = 0;
   int  last_v = 0;
   int  half_err = 0;
   int  first_act = 0;
   int  first_exp = 0;
   int  exp_halves = 0;
   int  done_cnt = 0;
   bit  done_prev = 1'b0;
   bit  stop_run = 1'b0;

   initial begin
      void'($urandom(32'd20240611));
      forever begin
         @(negedge clk);
         cyc++;
         if (done_prev) chk(done === 1'b0, "R7 width", int'(done), 0);
         if (apri_valid === 1'b1) begin
            int a;
            int e;
            logic [DW-1:0] nv;
            a = (run_half % 2 == 1) ? perm(run_k) : run_k;
            e = (run_half == 0) ? 0 : int'(model[a]);
            if (run_k == 0 && run_half > 0)
               chk(cyc - last_v == LAT + 2, "R10", cyc - last_v, LAT + 2);
            if (int'(apri_data) != e || ilv_phase !== 1'(run_half % 2)) begin
               if (half_err == 0) begin
                  first_act = int'(apri_data);
                  first_exp = e;
               end
               half_err++;
            end
            nv = DW'($urandom);
            model[a] = nv;
            hist[cyc % 16] = nv;
            last_v = cyc;
            run_k++;
            if (run_k == N) begin
               // checks R2 (zero first half), R3/R5 order, R4 write-back
               if (run_half == 0)         chk(half_err == 0, "R2", first_act, first_exp);
               else if (run_half % 2 == 1) chk(half_err == 0, "R3,R4", first_act, first_exp);
               else                        chk(half_err == 0, "R5,R4", first_act, first_exp);
               run_half++;
               run_k = 0;
               half_err = 0;
            end
         end
         ext_data = hist[(cyc - LAT) % 16];
         if (done === 1'b1) begin
            chk(cyc - last_v == LAT + 1, "R7", cyc - last_v, LAT + 1);
            chk(run_half == exp_halves, stop_run ? "R8" : "R6", run_half, exp_halves);
            chk(run_k == 0, "R7 partial", run_k, 0);
            done_cnt++;
            run_half = 0;
         end
         done_prev = (done === 1'b1);
      end
   end

   task automatic do_run(input int itv, input int exp_h, input int stop_at, input bit extra);
      int target;
      target = done_cnt + 1;
      @(negedge clk);
      iter_cnt   = CW'(itv);
      exp_halves = exp_h;
      stop_run   = (stop_at >= 0);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (stop_at >= 0) begin
         wait (run_half == stop_at && run_k == 100);
         stop = 1'b1;
      end
      if (extra) begin
         wait (run_half == 1 && run_k == 50);
         @(negedge clk);
         iter_cnt = CW'(1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (done_cnt == target);
      @(negedge clk);
      stop = 1'b0;
      repeat (6) @(negedge clk);
      if (extra) chk(done_cnt == target, "R9", done_cnt, target);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(apri_valid === 1'b0, "R1 valid", int'(apri_valid), 0);
      chk(done === 1'b0, "R1 done", int'(done), 0);
      rst_n = 1'b1;
      // stop high while idle has no effect
      stop = 1'b1;
      repeat (4) @(negedge clk);
      chk(apri_valid === 1'b0 && done === 1'b0, "R1 idle", int'(apri_valid), 0);
      stop = 1'b0;
      do_run(2, 4, -1, 1'b1);             // R9: stray start mid-run
      do_run(0, 2, -1, 1'b0);             // R6: zero counts as one
      do_run(7, 2 * MAXIT, -1, 1'b0);     // R6: clamp to limit
      do_run(5, 3, 2, 1'b0);              // R8: stop in half 2
      do_run(1 + ($urandom % MAXIT), -1, 0, 1'b0); // R8: stop in first half
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // the last run stops after half 0; its expected half count is fixed here
   always @(exp_halves) if (exp_halves == -1) exp_halves = 1;

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule